// File: doc/BRIEF.md
# Data ROM Pointer Read Unit

This unit streams bytes from a large data ROM through a small byte-wide register window. Software loads a 24-bit read pointer, a 16-bit adjust value, a 16-bit increment value and a mode byte. It then pulls bytes from the ROM through two read ports. The main port returns the byte at the pointer. The adjusted port returns the byte at the pointer plus the adjust value. Depending on the mode, either the pointer or the adjust register advances after port reads or after adjust writes. Several fetch patterns are possible this way: plain sequential reads, strided reads, table lookups relative to a base, and self-advancing offsets.

The ROM sits behind a simple synchronous read interface with one cycle of latency. A port read therefore holds the bus, with ready low, until the byte has come back. A plain register access answers in the next cycle.

Top module: `romptr_stream`

## Requirements
- R1: After reset the pointer, adjust, increment, stored mode and active mode are all zero. The bus is ready, with no response pending and no ROM strobe.
- R2: The window has these offsets. Pointer bytes sit at 1 (bits 7:0), 2 (bits 15:8) and 3 (bits 23:16, the bank counted from the start of the data ROM). Adjust bytes sit at 4 (low) and 5 (high). Increment bytes sit at 6 (low) and 7 (high). The stored mode byte sits at 8. A read of any of these offsets returns its current value, with bus_rvalid set in the cycle after the request is accepted. Other offsets read as zero.
- R3: A read of offset 0 (main port) returns the ROM byte at the pointer. A request is accepted only while bus_ready is high. For a port read, bus_ready is low for the next two cycles, and bus_rvalid and the byte appear in the third cycle. A request presented while bus_ready is low is ignored.
- R4: Mode bits [1:0] equal to 00 step the target by 1 after each main-port read. Pointer arithmetic wraps modulo 2^24.
- R5: Mode bits [1:0] equal to 01 step the target by the increment register after each main-port read. Mode bit 2 set sign-extends the increment; clear zero-extends it.
- R6: Mode bit 4 picks the target of every step. When clear, the step is added to the pointer. When set, it is added to the adjust register (mod 2^16) and the pointer stays unchanged.
- R7: A read of offset 9 (adjusted port) returns the ROM byte at pointer plus adjust. The adjust value is sign-extended when mode bit 3 is set and zero-extended otherwise.
- R8: With mode bits [1:0] equal to 10 and bits [6:5] equal to 01, every write to either adjust byte adds the new low adjust byte, extended per bit 3, to the target.
- R9: With mode bits [1:0] equal to 10 and bits [6:5] equal to 10, every write to either adjust byte adds the new 16-bit adjust value, extended per bit 3, to the target.
- R10: With mode bits [1:0] equal to 10 and bits [6:5] equal to 11, every adjusted-port read adds the 16-bit adjust value to the target. With bits [6:5] equal to 00 no addition happens. With bits [1:0] equal to 10 or 11, main-port reads do not step.
- R11: A mode write is stored at once but becomes active only after both adjust bytes have been written since that write, in either order. The additions triggered by an adjust write follow the mode that was active before that write.
- R12: Each port read raises rom_en for exactly one cycle, in the cycle after acceptance, with rom_addr set to the port's address. Register reads and writes never strobe the ROM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request, taken when bus_ready is high |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (4) | Register window offset |
| bus_wdata | input | 8 | Write byte |
| bus_ready | output | 1 | Unit can accept a request |
| bus_rvalid | output | 1 | One-cycle pulse: bus_rdata holds the read result |
| bus_rdata | output | 8 | Read result |
| rom_en | output | 1 | ROM read strobe |
| rom_addr | output | ROM_AW (24) | ROM byte address |
| rom_data | input | 8 | ROM byte, valid the cycle after rom_en |

## Verification
The assertions check the bus handshake shape on every cycle: the one-cycle ROM strobe, the fixed gap from strobe to response, and the absence of any strobe on register accesses. They also check that no state moves without an accepted request, that the active mode changes only on an adjust write, and that the unit-step case advances the pointer by one. Only the bench's scenarios can show the arithmetic: signed and unsigned extension, the redirection of steps into the adjust register, the 8-bit versus 16-bit adjust-write additions, the adjusted-port address, wrap-around at the 24-bit limit, and the delayed activation of a new mode. These are compared against a behavioural model on every clock.

// File: rtl/romptr_pkg.sv
`timescale 1ns/1ps
package romptr_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'b00,
    SEQ_LAUNCH = 2'b01,
    SEQ_FETCH  = 2'b10
  } seq_state_e;

  typedef enum logic [1:0] {
    STEP_ONE  = 2'b00,
    STEP_INC  = 2'b01,
    STEP_ADJ  = 2'b10,
    STEP_NONE = 2'b11
  } step_src_e;

  typedef enum logic [1:0] {
    ADD_OFF     = 2'b00,
    ADD_LOW_WR  = 2'b01,
    ADD_FULL_WR = 2'b10,
    ADD_ON_PORT = 2'b11
  } add_timing_e;

  typedef struct packed {
    logic        spare;
    add_timing_e timing;
    logic        to_adj;
    logic        adj_signed;
    logic        inc_signed;
    step_src_e   src;
  } mode_t;
endpackage

// File: rtl/romptr_step.sv
`timescale 1ns/1ps
module romptr_step
  import romptr_pkg::*;
#(
  parameter int PTR_W = 24,
  parameter int OFS_W = 16
) (
  input  mode_t             mode,
  input  logic [PTR_W-1:0]  ptr,
  input  logic [OFS_W-1:0]  adj,
  input  logic [OFS_W-1:0]  inc,
  input  logic [OFS_W-1:0]  adj_wr_val,
  output logic              main_go,
  output logic [PTR_W-1:0]  main_amt,
  output logic              port_go,
  output logic [PTR_W-1:0]  port_amt,
  output logic              wr_go,
  output logic [PTR_W-1:0]  wr_amt,
  output logic [PTR_W-1:0]  port_addr
);
  localparam int WORD_PAD = PTR_W - OFS_W;
  localparam int BYTE_PAD = PTR_W - BYTE_W;

  function automatic logic [PTR_W-1:0] widen_word(input logic [OFS_W-1:0] v, input logic sgn);
    widen_word = {{WORD_PAD{sgn & v[OFS_W-1]}}, v};
  endfunction

  function automatic logic [PTR_W-1:0] widen_byte(input logic [BYTE_W-1:0] v, input logic sgn);
    widen_byte = {{BYTE_PAD{sgn & v[BYTE_W-1]}}, v};
  endfunction

  logic [PTR_W-1:0] adj_ext;
  logic             unused_spare;

  assign unused_spare = mode.spare;

  always_comb begin
    adj_ext   = widen_word(adj, mode.adj_signed);
    port_addr = ptr + adj_ext;

    main_go  = (mode.src == STEP_ONE) || (mode.src == STEP_INC);
    main_amt = (mode.src == STEP_INC) ? widen_word(inc, mode.inc_signed) : PTR_W'(1);

    port_go  = (mode.src == STEP_ADJ) && (mode.timing == ADD_ON_PORT);
    port_amt = adj_ext;

    wr_go  = (mode.src == STEP_ADJ) &&
             ((mode.timing == ADD_LOW_WR) || (mode.timing == ADD_FULL_WR));
    wr_amt = (mode.timing == ADD_LOW_WR)
             ? widen_byte(adj_wr_val[BYTE_W-1:0], mode.adj_signed)
             : widen_word(adj_wr_val, mode.adj_signed);
  end
endmodule

// File: rtl/romptr_regs.sv
`timescale 1ns/1ps
module romptr_regs
  import romptr_pkg::*;
#(
  parameter int PTR_W     = 24,
  parameter int OFS_W     = 16,
  parameter int ADDR_W    = 4,
  parameter int PTR_BASE  = 1,
  parameter int ADJ_BASE  = 4,
  parameter int INC_BASE  = 6,
  parameter int MODE_BASE = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_wr,
  input  logic              acc_main,
  input  logic              acc_port,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              main_go,
  input  logic [PTR_W-1:0]  main_amt,
  input  logic              port_go,
  input  logic [PTR_W-1:0]  port_amt,
  input  logic              wr_go,
  input  logic [PTR_W-1:0]  wr_amt,
  output logic [PTR_W-1:0]  ptr,
  output logic [OFS_W-1:0]  adj,
  output logic [OFS_W-1:0]  inc,
  output mode_t             mode_act,
  output logic [OFS_W-1:0]  adj_wr_val,
  output logic [BYTE_W-1:0] rd_byte
);
  localparam int PTR_BYTES = PTR_W / BYTE_W;
  localparam int OFS_BYTES = OFS_W / BYTE_W;

  logic [PTR_W-1:0]     ptr_q, ptr_n;
  logic [OFS_W-1:0]     adj_q, adj_n;
  logic [OFS_W-1:0]     inc_q, inc_n;
  logic [BYTE_W-1:0]    pend_q, pend_n;
  mode_t                act_q, act_n;
  logic [OFS_BYTES-1:0] seen_q, seen_n;
  logic                 adj_hit;
  logic                 step_go;
  logic [PTR_W-1:0]     step_amt;

  // Adjust register with the incoming byte merged in
  always_comb begin
    adj_wr_val = adj_q;
    adj_hit    = 1'b0;
    for (int i = 0; i < OFS_BYTES; i++) begin
      if (acc_wr && addr == ADDR_W'(ADJ_BASE + i)) begin
        adj_wr_val[i*BYTE_W +: BYTE_W] = wdata;
        adj_hit = 1'b1;
      end
    end
  end

  // Step selection: at most one event per accepted request
  always_comb begin
    step_go  = 1'b0;
    step_amt = '0;
    if (acc_main && main_go) begin
      step_go  = 1'b1;
      step_amt = main_amt;
    end else if (acc_port && port_go) begin
      step_go  = 1'b1;
      step_amt = port_amt;
    end else if (adj_hit && wr_go) begin
      step_go  = 1'b1;
      step_amt = wr_amt;
    end
  end

  always_comb begin
    ptr_n  = ptr_q;
    adj_n  = adj_q;
    inc_n  = inc_q;
    pend_n = pend_q;
    act_n  = act_q;
    seen_n = seen_q;
    if (acc_wr) begin
      for (int i = 0; i < PTR_BYTES; i++) begin
        if (addr == ADDR_W'(PTR_BASE + i)) ptr_n[i*BYTE_W +: BYTE_W] = wdata;
      end
      for (int i = 0; i < OFS_BYTES; i++) begin
        if (addr == ADDR_W'(INC_BASE + i)) inc_n[i*BYTE_W +: BYTE_W] = wdata;
        if (addr == ADDR_W'(ADJ_BASE + i)) seen_n[i] = 1'b1;
      end
      if (adj_hit) adj_n = adj_wr_val;
      if (addr == ADDR_W'(MODE_BASE)) begin
        pend_n = wdata;
        seen_n = '0;
      end
    end
    if (step_go) begin
      if (act_q.to_adj) adj_n = adj_n + step_amt[OFS_W-1:0];
      else              ptr_n = ptr_n + step_amt;
    end
    if (adj_hit && (&seen_n)) act_n = mode_t'(pend_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q  <= '0;
      adj_q  <= '0;
      inc_q  <= '0;
      pend_q <= '0;
      act_q  <= '0;
      seen_q <= '0;
    end else begin
      ptr_q  <= ptr_n;
      adj_q  <= adj_n;
      inc_q  <= inc_n;
      pend_q <= pend_n;
      act_q  <= act_n;
      seen_q <= seen_n;
    end
  end

  always_comb begin
    rd_byte = '0;
    for (int i = 0; i < PTR_BYTES; i++) begin
      if (addr == ADDR_W'(PTR_BASE + i)) rd_byte = ptr_q[i*BYTE_W +: BYTE_W];
    end
    for (int i = 0; i < OFS_BYTES; i++) begin
      if (addr == ADDR_W'(ADJ_BASE + i)) rd_byte = adj_q[i*BYTE_W +: BYTE_W];
      if (addr == ADDR_W'(INC_BASE + i)) rd_byte = inc_q[i*BYTE_W +: BYTE_W];
    end
    if (addr == ADDR_W'(MODE_BASE)) rd_byte = pend_q;
  end

  assign ptr      = ptr_q;
  assign adj      = adj_q;
  assign inc      = inc_q;
  assign mode_act = act_q;
endmodule

// File: rtl/romptr_seq.sv
`timescale 1ns/1ps
module romptr_seq
  import romptr_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int PTR_W     = 24,
  parameter int ROM_AW    = 24,
  parameter int PORT_MAIN = 0,
  parameter int PORT_ADJ  = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] reg_byte,
  input  logic [PTR_W-1:0]  ptr,
  input  logic [PTR_W-1:0]  port_addr,
  input  logic [BYTE_W-1:0] rom_data,
  output logic              bus_ready,
  output logic              bus_rvalid,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              rom_en,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              acc_wr,
  output logic              acc_main,
  output logic              acc_port
);
  seq_state_e state_q;
  logic       accept;
  logic       acc_reg;

  always_comb begin
    accept   = bus_req && (state_q == SEQ_IDLE);
    acc_wr   = accept && bus_we;
    acc_main = accept && !bus_we && (bus_addr == ADDR_W'(PORT_MAIN));
    acc_port = accept && !bus_we && (bus_addr == ADDR_W'(PORT_ADJ));
    acc_reg  = accept && !bus_we && !acc_main && !acc_port;
  end

  assign bus_ready = (state_q == SEQ_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= SEQ_IDLE;
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
      rom_en     <= 1'b0;
      rom_addr   <= '0;
    end else begin
      bus_rvalid <= 1'b0;
      rom_en     <= 1'b0;
      unique case (state_q)
        SEQ_IDLE: begin
          if (acc_main || acc_port) begin
            rom_en   <= 1'b1;
            rom_addr <= acc_port ? port_addr[ROM_AW-1:0] : ptr[ROM_AW-1:0];
            state_q  <= SEQ_LAUNCH;
          end else if (acc_reg) begin
            bus_rdata  <= reg_byte;
            bus_rvalid <= 1'b1;
          end
        end
        SEQ_LAUNCH: state_q <= SEQ_FETCH;
        SEQ_FETCH: begin
          bus_rdata  <= rom_data;
          bus_rvalid <= 1'b1;
          state_q    <= SEQ_IDLE;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/romptr_stream.sv
`timescale 1ns/1ps
module romptr_stream
  import romptr_pkg::*;
#(
  parameter int PTR_W  = 24,
  parameter int OFS_W  = 16,
  parameter int ROM_AW = 24,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic              bus_ready,
  output logic              bus_rvalid,
  output logic [7:0]        bus_rdata,
  output logic              rom_en,
  output logic [ROM_AW-1:0] rom_addr,
  input  logic [7:0]        rom_data
);
  localparam int PTR_BYTES = PTR_W / BYTE_W;
  localparam int OFS_BYTES = OFS_W / BYTE_W;
  localparam int PORT_MAIN = 0;
  localparam int PTR_BASE  = 1;
  localparam int ADJ_BASE  = PTR_BASE + PTR_BYTES;
  localparam int INC_BASE  = ADJ_BASE + OFS_BYTES;
  localparam int MODE_BASE = INC_BASE + OFS_BYTES;
  localparam int PORT_ADJ  = MODE_BASE + 1;

  logic [PTR_W-1:0]  ptr_w, port_addr_w;
  logic [OFS_W-1:0]  adj_w, inc_w, adj_wr_val_w;
  mode_t             mode_act_w;
  logic [BYTE_W-1:0] reg_byte_w;
  logic              acc_wr_w, acc_main_w, acc_port_w;
  logic              main_go_w, port_go_w, wr_go_w;
  logic [PTR_W-1:0]  main_amt_w, port_amt_w, wr_amt_w;

  romptr_seq #(
    .ADDR_W(ADDR_W), .PTR_W(PTR_W), .ROM_AW(ROM_AW),
    .PORT_MAIN(PORT_MAIN), .PORT_ADJ(PORT_ADJ)
  ) u_seq (
    .clk(clk), .rst(rst),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .reg_byte(reg_byte_w), .ptr(ptr_w), .port_addr(port_addr_w),
    .rom_data(rom_data),
    .bus_ready(bus_ready), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
    .rom_en(rom_en), .rom_addr(rom_addr),
    .acc_wr(acc_wr_w), .acc_main(acc_main_w), .acc_port(acc_port_w)
  );

  romptr_step #(.PTR_W(PTR_W), .OFS_W(OFS_W)) u_step (
    .mode(mode_act_w), .ptr(ptr_w), .adj(adj_w), .inc(inc_w),
    .adj_wr_val(adj_wr_val_w),
    .main_go(main_go_w), .main_amt(main_amt_w),
    .port_go(port_go_w), .port_amt(port_amt_w),
    .wr_go(wr_go_w), .wr_amt(wr_amt_w),
    .port_addr(port_addr_w)
  );

  romptr_regs #(
    .PTR_W(PTR_W), .OFS_W(OFS_W), .ADDR_W(ADDR_W),
    .PTR_BASE(PTR_BASE), .ADJ_BASE(ADJ_BASE),
    .INC_BASE(INC_BASE), .MODE_BASE(MODE_BASE)
  ) u_regs (
    .clk(clk), .rst(rst),
    .acc_wr(acc_wr_w), .acc_main(acc_main_w), .acc_port(acc_port_w),
    .addr(bus_addr), .wdata(bus_wdata),
    .main_go(main_go_w), .main_amt(main_amt_w),
    .port_go(port_go_w), .port_amt(port_amt_w),
    .wr_go(wr_go_w), .wr_amt(wr_amt_w),
    .ptr(ptr_w), .adj(adj_w), .inc(inc_w), .mode_act(mode_act_w),
    .adj_wr_val(adj_wr_val_w), .rd_byte(reg_byte_w)
  );
endmodule

// File: rtl/romptr_stream_chk.sv
`timescale 1ns/1ps
module romptr_stream_chk #(
  parameter int PTR_W     = 24,
  parameter int OFS_W     = 16,
  parameter int ROM_AW    = 24,
  parameter int ADDR_W    = 4,
  parameter int PORT_MAIN = 0,
  parameter int PORT_ADJ  = 9,
  parameter int ADJ_BASE  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_ready,
  input logic              bus_rvalid,
  input logic              rom_en,
  input logic [PTR_W-1:0]  ptr,
  input logic [OFS_W-1:0]  adj,
  input logic [OFS_W-1:0]  inc,
  input logic [7:0]        mode_act
);
  localparam int OFS_BYTES = OFS_W / 8;

  logic accepted, port_rd, adj_wr;

  always_comb begin
    accepted = bus_req && bus_ready;
    port_rd  = accepted && !bus_we &&
               (bus_addr == ADDR_W'(PORT_MAIN) || bus_addr == ADDR_W'(PORT_ADJ));
    adj_wr   = 1'b0;
    for (int i = 0; i < OFS_BYTES; i++) begin
      if (accepted && bus_we && bus_addr == ADDR_W'(ADJ_BASE + i)) adj_wr = 1'b1;
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> bus_ready && !bus_rvalid && !rom_en && ptr == '0 && adj == '0 && mode_act == '0);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !accepted |=> $stable(ptr) && $stable(adj) && $stable(inc) && $stable(mode_act));

  // R3
  port_launch_chk: assert property (@(posedge clk) disable iff (rst)
    port_rd |=> rom_en && !bus_ready);

  // R3
  port_reply_chk: assert property (@(posedge clk) disable iff (rst)
    rom_en |=> !bus_rvalid && !bus_ready ##1 bus_rvalid && bus_ready);

  // R12
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rom_en |=> !rom_en);

  // R12
  reg_no_rom_chk: assert property (@(posedge clk) disable iff (rst)
    accepted && !port_rd |=> !rom_en);

  // R11
  mode_switch_chk: assert property (@(posedge clk) disable iff (rst)
    mode_act != $past(mode_act) |-> $past(adj_wr));

  // R4
  unit_step_chk: assert property (@(posedge clk) disable iff (rst)
    accepted && !bus_we && bus_addr == ADDR_W'(PORT_MAIN) && mode_act[1:0] == 2'b00 && !mode_act[4]
    |=> ptr == ($past(ptr) + {{(PTR_W-1){1'b0}}, 1'b1}));

  // R10
  no_main_step_chk: assert property (@(posedge clk) disable iff (rst)
    accepted && !bus_we && bus_addr == ADDR_W'(PORT_MAIN) && mode_act[1]
    |=> $stable(ptr) && $stable(adj));
endmodule

bind romptr_stream romptr_stream_chk #(
  .PTR_W(PTR_W), .OFS_W(OFS_W), .ROM_AW(ROM_AW), .ADDR_W(ADDR_W),
  .PORT_MAIN(PORT_MAIN), .PORT_ADJ(PORT_ADJ), .ADJ_BASE(ADJ_BASE)
) u_chk (
  .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_ready(bus_ready), .bus_rvalid(bus_rvalid), .rom_en(rom_en),
  .ptr(ptr_w), .adj(adj_w), .inc(inc_w), .mode_act(mode_act_w)
);

// File: tb/test_romptr_stream.sv
`timescale 1ns/1ps
module test_romptr_stream;
  logic        clk = 1'b0;
  logic        rst;
  logic        bus_req, bus_we;
  logic [3:0]  bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_ready, bus_rvalid;
  logic [7:0]  bus_rdata;
  logic        rom_en;
  logic [23:0] rom_addr;
  logic [7:0]  rom_data;

  int checks = 0;
  int failures = 0;

  // behavioural model state
  int unsigned m_ptr, m_adj, m_inc;
  logic [7:0]  m_pend, m_act;
  bit          m_seen_lo, m_seen_hi;

  always #4 clk = ~clk;

  romptr_stream i_romptr_stream (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rvalid(bus_rvalid),
    .bus_rdata(bus_rdata), .rom_en(rom_en), .rom_addr(rom_addr), .rom_data(rom_data)
  );

  function automatic logic [7:0] rom_byte(input logic [23:0] a);
    int unsigned v;
    v = ((32'(a) * 7) ^ (32'(a) >> 9) ^ ((32'(a) >> 16) * 13)) + 90;
    return v[7:0];
  endfunction

  always @(posedge clk) if (rom_en) rom_data <= rom_byte(rom_addr);

  function automatic int unsigned ext16(input int unsigned v, input bit sgn);
    int unsigned w = v & 32'hFFFF;
    if (sgn && w >= 32'h8000) w = w | 32'hFF0000;
    return w;
  endfunction

  function automatic int unsigned ext8(input int unsigned v, input bit sgn);
    int unsigned w = v & 32'hFF;
    if (sgn && w >= 32'h80) w = w | 32'hFFFF00;
    return w;
  endfunction

  task automatic model_step(input int unsigned amt);
    if (m_act[4]) m_adj = (m_adj + amt) & 32'hFFFF;
    else          m_ptr = (m_ptr + amt) & 32'hFFFFFF;
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input int unsigned act, input int unsigned exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic bus_cycle(input bit we, input int unsigned addr, input int unsigned data,
                           input int lat, input int unsigned exp, input int unsigned exp_rom,
                           input bit poke, input string tag);
    @(posedge clk); #1;
    bus_req = 1'b1; bus_we = we; bus_addr = 4'(addr); bus_wdata = 8'(data);
    @(negedge clk);
    check(bus_ready && !bus_rvalid, tag, "ready before accept", {bus_ready, bus_rvalid}, 2'b10);
    @(posedge clk); #1;
    if (poke) begin
      bus_we = 1'b1; bus_addr = 4'd1; bus_wdata = 8'hEE;
    end else bus_req = 1'b0;
    if (lat == 0) begin
      @(negedge clk);
      check(bus_ready && !bus_rvalid, tag, "write no response", {bus_ready, bus_rvalid}, 2'b10);
    end
    for (int k = 1; k <= lat; k++) begin
      @(negedge clk);
      if (k == lat) begin
        check(bus_rvalid && bus_ready, tag, "response valid", {bus_ready, bus_rvalid}, 2'b11);
        check(bus_rdata == 8'(exp), tag, "read data", bus_rdata, exp);
      end else begin
        check(!bus_rvalid && !bus_ready, tag, "busy wait", {bus_ready, bus_rvalid}, 2'b00);
        if (k == 1) begin
          check(rom_en && rom_addr == 24'(exp_rom), tag, "rom strobe address", rom_addr, exp_rom);
          if (poke) begin
            @(posedge clk); #1;
            bus_req = 1'b0;
          end
        end else begin
          check(!rom_en, tag, "rom strobe single cycle", rom_en, 0);
        end
      end
    end
  endtask

  task automatic do_write(input int unsigned addr, input int unsigned data, input string tag);
    case (addr)
      1: m_ptr = (m_ptr & 32'hFFFF00) | (data & 32'hFF);
      2: m_ptr = (m_ptr & 32'hFF00FF) | ((data & 32'hFF) << 8);
      3: m_ptr = (m_ptr & 32'h00FFFF) | ((data & 32'hFF) << 16);
      4, 5: begin
        if (addr == 4) begin m_adj = (m_adj & 32'hFF00) | (data & 32'hFF); m_seen_lo = 1; end
        else begin m_adj = (m_adj & 32'h00FF) | ((data & 32'hFF) << 8); m_seen_hi = 1; end
        if (m_act[1:0] == 2'b10 && m_act[6:5] == 2'b01) model_step(ext8(m_adj, m_act[3]));
        if (m_act[1:0] == 2'b10 && m_act[6:5] == 2'b10) model_step(ext16(m_adj, m_act[3]));
        if (m_seen_lo && m_seen_hi) m_act = m_pend;
      end
      6: m_inc = (m_inc & 32'hFF00) | (data & 32'hFF);
      7: m_inc = (m_inc & 32'h00FF) | ((data & 32'hFF) << 8);
      8: begin m_pend = 8'(data); m_seen_lo = 0; m_seen_hi = 0; end
      default: ;
    endcase
    bus_cycle(1'b1, addr, data, 0, 0, 0, 1'b0, tag);
  endtask

  task automatic do_read(input int unsigned addr, input string tag, input bit poke = 1'b0);
    int unsigned exp, a;
    case (addr)
      0: begin
        a = m_ptr;
        exp = rom_byte(24'(a));
        if (m_act[1:0] == 2'b00) model_step(1);
        if (m_act[1:0] == 2'b01) model_step(ext16(m_inc, m_act[2]));
        bus_cycle(1'b0, addr, 0, 3, exp, a, poke, tag);
      end
      9: begin
        a = (m_ptr + ext16(m_adj, m_act[3])) & 32'hFFFFFF;
        exp = rom_byte(24'(a));
        if (m_act[1:0] == 2'b10 && m_act[6:5] == 2'b11) model_step(ext16(m_adj, m_act[3]));
        bus_cycle(1'b0, addr, 0, 3, exp, a, poke, tag);
      end
      default: begin
        case (addr)
          1: exp = m_ptr & 32'hFF;
          2: exp = (m_ptr >> 8) & 32'hFF;
          3: exp = (m_ptr >> 16) & 32'hFF;
          4: exp = m_adj & 32'hFF;
          5: exp = (m_adj >> 8) & 32'hFF;
          6: exp = m_inc & 32'hFF;
          7: exp = (m_inc >> 8) & 32'hFF;
          8: exp = 32'(m_pend);
          default: exp = 0;
        endcase
        bus_cycle(1'b0, addr, 0, 1, exp, 0, 1'b0, tag);
      end
    endcase
  endtask

  task automatic read_ptr(input string tag);
    for (int i = 1; i <= 3; i++) do_read(i, tag);
  endtask

  task automatic read_adj(input string tag);
    do_read(4, tag);
    do_read(5, tag);
  endtask

  task automatic set_mode(input int unsigned mode, input int unsigned lo, input int unsigned hi,
                          input string tag);
    do_write(8, mode, tag);
    do_write(4, lo, tag);
    do_write(5, hi, tag);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    m_ptr = 0; m_adj = 0; m_inc = 0; m_pend = 0; m_act = 0; m_seen_lo = 0; m_seen_hi = 0;
    rst = 1'b1; bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state at the ports
    check(bus_ready && !bus_rvalid && !rom_en, "R1", "reset outputs",
          {bus_ready, bus_rvalid, rom_en}, 3'b100);
    for (int a = 1; a <= 8; a++) do_read(a, "R1");

    // R2 register readback and unmapped offsets
    do_write(1, 8'h34, "R2"); do_write(2, 8'h12, "R2"); do_write(3, 8'h05, "R2");
    do_write(6, 8'h10, "R2"); do_write(7, 8'h22, "R2");
    read_ptr("R2"); do_read(6, "R2"); do_read(7, "R2");
    do_write(8, 8'h55, "R2"); do_read(8, "R2");
    do_write(8, 8'h00, "R2");
    do_read(12, "R2"); do_read(15, "R2");

    // R3 R4 sequential main reads
    for (int i = 0; i < 4; i++) do_read(0, "R3");
    read_ptr("R4");
    // R4 wrap at the 24-bit limit
    do_write(1, 8'hFF, "R4"); do_write(2, 8'hFF, "R4"); do_write(3, 8'hFF, "R4");
    do_read(0, "R4"); do_read(0, "R4");
    read_ptr("R4");

    // R11 delayed activation, R5 increment step
    do_write(1, 8'h00, "R11"); do_write(2, 8'h20, "R11"); do_write(3, 8'h00, "R11");
    do_write(6, 8'h00, "R11"); do_write(7, 8'h01, "R11");
    do_write(8, 8'h01, "R11");
    do_read(0, "R11"); read_ptr("R11");
    do_write(5, 8'h00, "R11");
    do_read(0, "R11"); read_ptr("R11");
    do_write(4, 8'h00, "R11");
    do_read(0, "R5"); read_ptr("R5");
    // R5 signed increment
    do_write(6, 8'hFE, "R5"); do_write(7, 8'hFF, "R5");
    set_mode(8'h05, 8'h00, 8'h00, "R5");
    do_read(0, "R5"); do_read(0, "R5"); read_ptr("R5");
    // R5 same increment unsigned
    set_mode(8'h01, 8'h00, 8'h00, "R5");
    do_read(0, "R5"); read_ptr("R5");

    // R6 step redirected to the adjust register
    do_write(6, 8'h30, "R6"); do_write(7, 8'h00, "R6");
    set_mode(8'h11, 8'h10, 8'h00, "R6");
    do_read(0, "R6"); do_read(0, "R6");
    read_adj("R6"); read_ptr("R6");

    // R7 adjusted port, unsigned then signed, timing 00
    set_mode(8'h02, 8'h80, 8'h00, "R7");
    do_read(9, "R7"); read_ptr("R10");
    set_mode(8'h0A, 8'hF0, 8'hFF, "R7");
    do_read(9, "R7"); read_ptr("R10");
    do_read(0, "R10"); read_ptr("R10");

    // R8 8-bit add on adjust write, signed
    set_mode(8'h2A, 8'h00, 8'h00, "R8");
    do_write(4, 8'hFC, "R8"); read_ptr("R8");
    do_write(5, 8'h01, "R8"); read_ptr("R8");

    // R9 16-bit add on adjust write, unsigned
    set_mode(8'h42, 8'h00, 8'h00, "R9");
    do_write(4, 8'h20, "R9"); read_ptr("R9");
    do_write(5, 8'h01, "R9"); read_ptr("R9");
    // R9 with the adjust register as target
    set_mode(8'h52, 8'h00, 8'h00, "R9");
    do_write(4, 8'h03, "R9"); read_adj("R9"); read_ptr("R9");

    // R10 add after adjusted-port read
    set_mode(8'h62, 8'h05, 8'h00, "R10");
    do_read(9, "R10"); do_read(9, "R10"); read_ptr("R10");
    do_read(0, "R10"); read_ptr("R10");
    // R10 unused step source: no step
    set_mode(8'h03, 8'h00, 8'h00, "R10");
    do_read(0, "R10"); read_ptr("R10");

    // R3 R12 request during busy is ignored
    set_mode(8'h00, 8'h00, 8'h00, "R12");
    do_write(1, 8'h40, "R12");
    do_read(0, "R3", 1'b1);
    read_ptr("R3");
    do_read(9, "R12"); read_ptr("R12");

    finish_run();
  end
endmodule